// File: doc/BRIEF.md
# Multi-Pixel Streaming Window Generator

This block sits between a raster pixel stream and a row of parallel processing elements. Each input beat carries `LANES` 8-bit pixels of one image row, and pixels arrive left to right, top to bottom. For every beat the block builds a neighbourhood window that is `KSIZE` rows tall and `KSIZE+LANES-1` columns wide. From that window, `LANES` processing elements can each compute one output pixel in the same cycle. A new beat can be accepted on every clock, so the block sustains `LANES` result pixels per clock.

Earlier rows are held in a single chain of registers. Each stored row's tail feeds the head of the next row, and the chain moves by `LANES` pixels on every beat. The pixels at the head of each stored row, together with the incoming beat, form a column block of `KSIZE` x `LANES` pixels. That block enters the right edge of the window in the same cycle as the chain shift, while the older window columns move left by `LANES`.

The processing elements are outside the block. Their `LANES` results return on `pe_res` after a fixed `PE_LAT` cycles. The block joins them into one output beat and marks that beat valid only when every lane's window lay wholly inside the image. Image width, image height, kernel size, lane count and processing-element latency are all compile-time parameters, and the image width must be a multiple of the lane count.

Top module: `mpx_window_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `win_valid` and `out_valid` are low.
- R2: `win_valid` is high in the cycle after each accepted beat (`in_valid` high at a clock edge) and low in every other cycle.
- R3: The window byte at row k (row 0 at the top) and column c (column 0 at the left) sits at `win_pix[8*(k*(KSIZE+LANES-1)+c) +: 8]`. For a beat at image row r and column block b, that byte is image pixel (r-KSIZE+1+k, b*LANES-KSIZE+1+c). Lane j of a beat (`in_pix[8*j +: 8]`) is image column b*LANES+j.
- R4: Window rows above the bottom row come from the line store: row k holds the same columns as the beat, taken KSIZE-1-k image rows earlier. This still holds at a row's first column block, where the stored rows wrap from one row's tail to the next row's head.
- R5: The leftmost KSIZE-1 window columns are the rightmost KSIZE-1 columns of the previous window (horizontal stride of LANES pixels).
- R6: `out_valid` rises exactly PE_LAT+1 cycles after a beat is accepted, and only if that beat's row index r >= KSIZE-1 and its column block index satisfies b*LANES >= KSIZE-1. Otherwise `out_valid` stays low.
- R7: When `out_valid` is high, `out_pix` byte j equals `pe_res` byte j, the result for the window position whose left column is b*LANES-KSIZE+1+j.
- R8: After IMG_ROWS rows the row and column tracking restarts, so the first KSIZE-1 rows of the next frame produce no output beat.
- R9: Idle cycles (`in_valid` low) leave the window, the line store and the position tracking unchanged. Back-to-back beats are all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_pix | input | LANES*8 | Input pixels, lane 0 leftmost |
| win_valid | output | 1 | Window updated this cycle |
| win_pix | output | KSIZE*(KSIZE+LANES-1)*8 | Window pixels, row-major |
| pe_res | input | LANES*8 | Processing-element results, PE_LAT cycles after the window |
| out_valid | output | 1 | Output beat valid |
| out_pix | output | LANES*8 | Joined result pixels, lane 0 leftmost |

## Verification
On every beat, the chain shift and the read of the stored row heads fall in the same clock. The window must therefore see the heads as they stood before the shift, including on the beat that begins a new row, where the heads are the previous rows' first pixels. The second overlap is a new beat being accepted in the same cycle as an older beat's result leaves on `out_pix`. Runs of back-to-back beats across row and frame boundaries provoke both overlaps, and a second frame with scattered idle cycles shows that gaps do not disturb either one. Every cycle, a behavioural model that indexes the image by row and column is compared with the window contents, `win_valid`, `out_valid` and `out_pix`.

// File: rtl/mwg_pkg.sv
`timescale 1ns/1ps
// mwg_pkg: shared constants and helpers for the window generator.
// Assumes 8-bit grayscale pixels throughout.
package mwg_pkg;
    localparam int PIX_BITS = 8;

    // Integer ceiling division, used for the first fully valid column block.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/mwg_line_store.sv
`timescale 1ns/1ps
// mwg_line_store: holds the KSIZE-1 previous image rows as one register chain.
// Each row's tail is linked to the next row's head, so a move of LANES pixels
// per beat keeps the last (KSIZE-1)*IMG_COLS pixels in raster order.
// Assumes KSIZE >= 2 and IMG_COLS > LANES. Index 0 of the chain is the oldest pixel.
module mwg_line_store import mwg_pkg::*; #(
    parameter int LANES    = 4,
    parameter int KSIZE    = 3,
    parameter int IMG_COLS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic [LANES*PIX_BITS-1:0]     in_pix,
    output logic [KSIZE*LANES*PIX_BITS-1:0] blk_pix
);
    localparam int BEAT_BITS  = LANES * PIX_BITS;
    localparam int ROW_BITS   = IMG_COLS * PIX_BITS;
    localparam int CHAIN_BITS = (KSIZE - 1) * ROW_BITS;

    logic [CHAIN_BITS-1:0] chain_q;

    // Move the whole chain by one beat; the newest pixels enter at the top end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (shift_en) begin
            chain_q <= {in_pix, chain_q[CHAIN_BITS-1:BEAT_BITS]};
        end
    end

    // Column block: head of each stored row (oldest on top), incoming beat at the bottom.
    for (genvar gi = 0; gi < KSIZE - 1; gi++) begin : g_heads
        assign blk_pix[gi*BEAT_BITS +: BEAT_BITS] = chain_q[gi*ROW_BITS +: BEAT_BITS];
    end
    assign blk_pix[(KSIZE-1)*BEAT_BITS +: BEAT_BITS] = in_pix;

    // R9: the stored rows do not move without a beat.
    a_r9_chain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain_q));
endmodule

// File: rtl/mwg_slide_window.sv
`timescale 1ns/1ps
// mwg_slide_window: KSIZE x (KSIZE+LANES-1) register array of pixels.
// On each beat every row moves left by LANES pixels and the new column block
// fills the rightmost LANES columns. Row 0 is the top, column 0 the left.
module mwg_slide_window import mwg_pkg::*; #(
    parameter int LANES = 4,
    parameter int KSIZE = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   shift_en,
    input  logic [KSIZE*LANES*PIX_BITS-1:0]        blk_pix,
    output logic                                   win_valid,
    output logic [KSIZE*(KSIZE+LANES-1)*PIX_BITS-1:0] win_pix
);
    localparam int WIN_COLS  = KSIZE + LANES - 1;
    localparam int BEAT_BITS = LANES * PIX_BITS;
    localparam int WROW_BITS = WIN_COLS * PIX_BITS;

    logic [KSIZE*WROW_BITS-1:0] win_q;
    logic                       wv_q;

    for (genvar gk = 0; gk < KSIZE; gk++) begin : g_rows
        // Slide one window row and append the block's pixels for that row.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q[gk*WROW_BITS +: WROW_BITS] <= '0;
            end else if (shift_en) begin
                win_q[gk*WROW_BITS +: WROW_BITS] <=
                    {blk_pix[gk*BEAT_BITS +: BEAT_BITS],
                     win_q[gk*WROW_BITS + BEAT_BITS +: WROW_BITS - BEAT_BITS]};
            end
        end
    end

    // Flag the cycle in which a freshly formed window is on the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) wv_q <= 1'b0;
        else        wv_q <= shift_en;
    end

    assign win_pix   = win_q;
    assign win_valid = wv_q;

    // R2: a window follows each beat and only a beat.
    a_r2_win_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> win_valid);
    a_r2_no_idle_window: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> !win_valid);
    // R9: idle cycles keep the window contents.
    a_r9_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(win_pix));
endmodule

// File: rtl/mwg_pos_track.sv
`timescale 1ns/1ps
// mwg_pos_track: column block and row counters for the incoming stream, and a
// keep flag delayed to line up with the processing elements' results.
// Assumes IMG_COLS is a multiple of LANES, KSIZE >= 2 and PE_LAT >= 1.
module mwg_pos_track import mwg_pkg::*; #(
    parameter int LANES    = 4,
    parameter int KSIZE    = 3,
    parameter int IMG_COLS = 16,
    parameter int IMG_ROWS = 6,
    parameter int PE_LAT   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic out_valid
);
    localparam int NBLK      = IMG_COLS / LANES;
    localparam int CW        = (NBLK > 1) ? $clog2(NBLK) : 1;
    localparam int RW        = (IMG_ROWS > 1) ? $clog2(IMG_ROWS) : 1;
    localparam int FIRST_BLK = ceil_div(KSIZE - 1, LANES);
    localparam logic [CW-1:0] LAST_COL  = CW'(NBLK - 1);
    localparam logic [RW-1:0] LAST_ROW  = RW'(IMG_ROWS - 1);
    localparam logic [CW-1:0] KEEP_COL  = CW'(FIRST_BLK);
    localparam logic [RW-1:0] KEEP_ROW  = RW'(KSIZE - 1);

    logic [CW-1:0]   col_blk;
    logic [RW-1:0]   row_cnt;
    logic [PE_LAT:0] keep_pipe;
    logic            last_col, last_row, keep_now;

    assign last_col = (col_blk == LAST_COL);
    assign last_row = (row_cnt == LAST_ROW);
    assign keep_now = (row_cnt >= KEEP_ROW) && (col_blk >= KEEP_COL);

    // Advance the raster position on each beat; wrap at row and frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_blk <= '0;
            row_cnt <= '0;
        end else if (in_valid) begin
            if (last_col) begin
                col_blk <= '0;
                row_cnt <= last_row ? '0 : row_cnt + 1'b1;
            end else begin
                col_blk <= col_blk + 1'b1;
            end
        end
    end

    // Carry the keep decision alongside the window and through the PE latency.
    always_ff @(posedge clk) begin
        if (!rst_n) keep_pipe <= '0;
        else        keep_pipe <= {keep_pipe[PE_LAT-1:0], in_valid && keep_now};
    end

    assign out_valid = keep_pipe[PE_LAT];

    // R8: the last beat of a frame returns the position to the top-left.
    a_r8_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && last_col && last_row) |=> (row_cnt == '0 && col_blk == '0));
    // R9: no position change without a beat.
    a_r9_idle_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(col_blk) && $stable(row_cnt)));
    // R6: a kept position only ever comes from an accepted beat.
    a_r6_keep_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !keep_pipe[0]);
endmodule

// File: rtl/mpx_window_gen.sv
`timescale 1ns/1ps
// mpx_window_gen: multi-pixel streaming window generator.
// Accepts LANES pixels per beat in raster order, presents a sliding window for
// LANES external processing elements, and joins their results into one beat.
// Assumes the processing elements have a fixed latency of PE_LAT cycles from
// win_pix to pe_res, and that IMG_COLS is a multiple of LANES.
module mpx_window_gen import mwg_pkg::*; #(
    parameter int LANES    = 4,
    parameter int KSIZE    = 3,
    parameter int IMG_COLS = 16,
    parameter int IMG_ROWS = 6,
    parameter int PE_LAT   = 2
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        in_valid,
    input  logic [LANES*PIX_BITS-1:0]                   in_pix,
    output logic                                        win_valid,
    output logic [KSIZE*(KSIZE+LANES-1)*PIX_BITS-1:0]   win_pix,
    input  logic [LANES*PIX_BITS-1:0]                   pe_res,
    output logic                                        out_valid,
    output logic [LANES*PIX_BITS-1:0]                   out_pix
);
    logic [KSIZE*LANES*PIX_BITS-1:0] blk_pix;

    mwg_line_store #(.LANES(LANES), .KSIZE(KSIZE), .IMG_COLS(IMG_COLS)) u_store (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
        .in_pix(in_pix), .blk_pix(blk_pix)
    );

    mwg_slide_window #(.LANES(LANES), .KSIZE(KSIZE)) u_window (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
        .blk_pix(blk_pix), .win_valid(win_valid), .win_pix(win_pix)
    );

    mwg_pos_track #(.LANES(LANES), .KSIZE(KSIZE), .IMG_COLS(IMG_COLS),
                    .IMG_ROWS(IMG_ROWS), .PE_LAT(PE_LAT)) u_track (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid)
    );

    // Join the lane results: lane j lands in byte j of the output beat.
    for (genvar gj = 0; gj < LANES; gj++) begin : g_join
        assign out_pix[gj*PIX_BITS +: PIX_BITS] = pe_res[gj*PIX_BITS +: PIX_BITS];
    end
endmodule

// File: tb/mpx_window_gen_tb_top.sv
`timescale 1ns/1ps
module mpx_window_gen_tb_top;
    localparam int W   = 4;
    localparam int K   = 3;
    localparam int C   = 16;
    localparam int R   = 6;
    localparam int LAT = 2;
    localparam int WW  = K + W - 1;
    localparam int NB  = C / W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W*8-1:0] in_pix = '0;
    logic win_valid, out_valid;
    logic [K*WW*8-1:0] win_pix;
    logic [W*8-1:0] pe_res, out_pix;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mpx_window_gen #(.LANES(W), .KSIZE(K), .IMG_COLS(C), .IMG_ROWS(R), .PE_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .win_valid(win_valid), .win_pix(win_pix), .pe_res(pe_res),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    // Image content for frame f, row r, column c.
    function automatic int pix(input int f, input int r, input int c);
        return (r*37 + c*11 + f*91 + r*c*3 + 5) & 255;
    endfunction

    // Stand-in processing element: weighted sum of the lane's KxK patch.
    function automatic logic [W*8-1:0] pe_fn(input logic [K*WW*8-1:0] wv);
        logic [W*8-1:0] res;
        for (int j = 0; j < W; j++) begin
            int acc = 0;
            for (int k = 0; k < K; k++)
                for (int c = 0; c < K; c++)
                    acc += int'(wv[(k*WW+j+c)*8 +: 8]) * (k*K + c + 1);
            res[j*8 +: 8] = acc[7:0];
        end
        return res;
    endfunction

    // Same weighted sum, computed from image coordinates.
    function automatic logic [W*8-1:0] exp_res(input int f, input int r, input int b);
        logic [W*8-1:0] res;
        for (int j = 0; j < W; j++) begin
            int acc = 0;
            for (int k = 0; k < K; k++)
                for (int c = 0; c < K; c++)
                    acc += pix(f, r-K+1+k, b*W-K+1+j+c) * (k*K + c + 1);
            res[j*8 +: 8] = acc[7:0];
        end
        return res;
    endfunction

    // Processing-element model with LAT pipeline stages.
    logic [W*8-1:0] pe_pipe [LAT];
    always @(posedge clk) begin
        pe_pipe[0] <= pe_fn(win_pix);
        for (int i = 1; i < LAT; i++) pe_pipe[i] <= pe_pipe[i-1];
    end
    assign pe_res = pe_pipe[LAT-1];

    bit             exp_v   [LAT+2];
    logic [W*8-1:0] exp_d   [LAT+2];
    string          exp_tag [LAT+2];
    bit pend_v = 1'b0;
    int pend_f = 0, pend_r = 0, pend_b = 0;

    task automatic fail(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        errors++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    // Compare the window with image coordinates (pixels inside the frame only).
    task automatic check_window();
        checks++;
        for (int k = 0; k < K; k++) begin
            for (int c = 0; c < WW; c++) begin
                int rr = pend_r - K + 1 + k;
                int cc = pend_b*W - K + 1 + c;
                logic [7:0] got = win_pix[(k*WW+c)*8 +: 8];
                logic [7:0] want = 8'(pix(pend_f, rr, cc));
                if (rr >= 0 && cc >= 0 && got !== want) begin
                    string tg = (k < K-1) ? "R4" : ((c < K-1) ? "R5" : "R3");
                    fail(tg, $sformatf("window k=%0d c=%0d", k, c), 64'(got), 64'(want));
                    return;
                end
            end
        end
    endtask

    // One cycle: check outputs at the falling edge, then drive the next input.
    task automatic step(input bit v, input int f, input int r, input int b, input string idle_tag);
        for (int i = 0; i <= LAT; i++) begin
            exp_v[i] = exp_v[i+1]; exp_d[i] = exp_d[i+1]; exp_tag[i] = exp_tag[i+1];
        end
        exp_v[LAT+1] = 1'b0; exp_tag[LAT+1] = idle_tag;
        checks++;
        if (out_valid !== exp_v[0]) fail(exp_tag[0], "out_valid", 64'(out_valid), 64'(exp_v[0]));
        else if (exp_v[0]) begin
            checks++;
            if (out_pix !== exp_d[0]) fail("R7", "out_pix", 64'(out_pix), 64'(exp_d[0]));
        end
        checks++;
        if (win_valid !== pend_v) fail("R2", "win_valid", 64'(win_valid), 64'(pend_v));
        else if (pend_v) check_window();
        pend_v = v; pend_f = f; pend_r = r; pend_b = b;
        in_valid = v;
        if (v) begin
            bit keep = (r >= K-1) && (b*W >= K-1);
            for (int j = 0; j < W; j++) in_pix[j*8 +: 8] = 8'(pix(f, r, b*W + j));
            exp_v[LAT+1] = keep;
            exp_d[LAT+1] = keep ? exp_res(f, r, b) : '0;
            exp_tag[LAT+1] = (f > 0 && r < K-1) ? "R8" : "R6";
        end
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < LAT+2; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_tag[i] = "R1"; end
        repeat (3) @(negedge clk);
        checks++;  // R1: outputs low while reset is held
        if (win_valid !== 1'b0 || out_valid !== 1'b0)
            fail("R1", "valids in reset", 64'({win_valid, out_valid}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        for (int f = 0; f < 2; f++) begin
            for (int r = 0; r < R; r++) begin
                for (int b = 0; b < NB; b++) begin
                    // R9: gaps in the second frame, back-to-back beats in the first.
                    if (f == 1 && ((r + b) % 3 == 0)) step(1'b0, 0, 0, 0, "R9");
                    step(1'b1, f, r, b, "R6");
                end
            end
        end
        for (int i = 0; i < LAT + 4; i++) step(1'b0, 0, 0, 0, "R9");
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule